// File: doc/BRIEF.md
# I2C Bus-Ownership and Start/Stop Request Controller

This block keeps track of whether a shared I2C bus is in use, on behalf of a controller that may act as one of several masters. It watches synchronized copies of the clock and data lines, recognises start and stop conditions, and keeps a busy flag. The flag is forced to a known value when the block is switched on, and an option bit chooses that value. Software asks for a start or a stop condition through one-cycle write strobes. The block turns these into single-cycle drive requests for a separate bit-level engine that shapes the actual waveforms.

A start request is accepted only when the bus is free or when the block already owns the bus, which gives a repeated start. Otherwise the request is dropped without any bus activity. In both cases the outcome appears on a status flag a fixed number of clocks after the write. A release strobe makes the block stop listening to the current transfer. Clearing the enable input returns every piece of state to idle. A stop condition seen on the lines can raise a one-cycle interrupt when that interrupt is enabled.

Top module: `i2c_bus_ctrl`

## Requirements
- R1: After reset, with `enable` low, every output is 0.
- R2: On the first clock edge that samples `enable` high with `free_on_enable` = 0, `bus_busy` becomes 1. It stays 1 whatever the idle line level is, until a stop condition is detected.
- R3: On the first clock edge that samples `enable` high with `free_on_enable` = 1, `bus_busy` becomes 0.
- R4: With the block enabled, SDA falling while SCL is high (start) sets `bus_busy` and `participating`. SDA rising while SCL is high (stop) clears `bus_busy`, `participating` and `is_master`. Either effect appears on the third rising edge that samples the line change. An SDA edge while SCL is low has no effect.
- R5: A start write sets `start_pending` on its edge. If the bus is free, the next edge clears `start_pending`, pulses `drive_start` for one cycle and sets `is_master`. On the edge after that, `bus_busy` is 1.
- R6: If the bus is busy and `is_master` is 0, a pending start is rejected. `start_pending` clears on the next edge, `drive_start` stays 0 and `is_master` stays 0.
- R7: `start_done` takes the outcome of a start write (1 accepted, 0 rejected) on exactly the fifth rising edge after the edge that samples the write. It holds its old value on the edges before that.
- R8: A stop write is served on the next edge: `drive_stop` pulses for one cycle, `stop_pending` clears and `is_master` clears. `bus_busy` stays 1 until the stop is seen on the lines. A pending stop is served before a pending start, and `drive_start` and `drive_stop` are never high together.
- R9: `stop_irq` is a one-cycle pulse on the same edge where a detected stop clears `bus_busy`, and only when `stop_irq_en` is 1.
- R10: A release write clears `participating` and `is_master` on the next edge and leaves `bus_busy` unchanged. `participating` stays 0 until a new start is detected.
- R11: With `enable` low, the next edge clears `bus_busy`, `start_pending`, `stop_pending`, `start_done`, `is_master` and `participating`. Writes made while disabled are ignored.
- R12: A start write while `is_master` is 1 is accepted even though the bus is busy (a repeated start): `drive_start` pulses on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| enable | input | 1 | Block enable; low clears all state |
| free_on_enable | input | 1 | 1: bus assumed free at enable; 0: assumed busy |
| start_wr | input | 1 | One-cycle strobe requesting a start condition |
| stop_wr | input | 1 | One-cycle strobe requesting a stop condition |
| release_wr | input | 1 | One-cycle strobe abandoning the current transfer |
| stop_irq_en | input | 1 | Enables the stop-detected interrupt |
| bus_busy | output | 1 | Bus considered in use |
| start_done | output | 1 | Outcome of the last start request (1 accepted) |
| start_pending | output | 1 | Start request waiting to be taken |
| stop_pending | output | 1 | Stop request waiting to be taken |
| drive_start | output | 1 | One-cycle request to the bit engine to make a start |
| drive_stop | output | 1 | One-cycle request to the bit engine to make a stop |
| is_master | output | 1 | Block owns the bus |
| participating | output | 1 | Block follows the current transfer |
| stop_irq | output | 1 | One-cycle stop-detected interrupt |

## Verification
Each result has a fixed latency. A line change reaches `bus_busy`, `participating` and `stop_irq` on the third edge. The pending bits follow a write on its own edge, and the drive pulses and `is_master` one edge later. `start_done` changes on the fifth edge after the write, and clearing `enable` takes effect one edge later. The bench drives its inputs on falling edges and counts rising edges from that point. It samples at the due edge, and for the busy and status results it also samples one edge earlier to show that nothing changed early.

// File: rtl/i2c_bus_pkg.sv
// Package: shared types and defaults for the I2C bus-ownership controller.
// Assumes: consumers import it before declaring ports that use bus_evt_t.
package i2c_bus_pkg;
    // Edge count from a start write to the status update
    localparam int unsigned STAT_DELAY_DEF = 5;
    // Synchronizer depth for the raw bus lines
    localparam int unsigned SYNC_DEF = 2;

    // Conditions decoded from the sampled lines
    typedef struct packed {
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2c_line_mon.sv
// Module: i2c_line_mon
// Synchronizes raw SCL/SDA and decodes start and stop conditions by comparing
// the newest synchronized sample with the one before it.
// Assumes: STAGES >= 2; an idle bus reads high, so reset fills all flops with 1.
module i2c_line_mon
    import i2c_bus_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains, one flop per stage
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw line
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_sh[0] <= 1'b1;
                        sda_sh[0] <= 1'b1;
                    end else begin
                        scl_sh[0] <= scl_raw;
                        sda_sh[0] <= sda_raw;
                    end
                end
            end else begin : g_next
                // Later stages pass the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_sh[g] <= 1'b1;
                        sda_sh[g] <= 1'b1;
                    end else begin
                        scl_sh[g] <= scl_sh[g-1];
                        sda_sh[g] <= sda_sh[g-1];
                    end
                end
            end
        end
    endgenerate

    // Previous synchronized sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_sh[LAST];
            sda_prev <= sda_sh[LAST];
        end
    end

    // Condition decode: SDA edge while SCL high in both samples
    always_comb begin
        evt.start = scl_prev & scl_sh[LAST] & sda_prev & ~sda_sh[LAST];
        evt.stop  = scl_prev & scl_sh[LAST] & ~sda_prev & sda_sh[LAST];
    end

    // R4: a start needs SDA seen high one sample earlier
    assert_start_needs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |-> $past(sda_sh[LAST]));
endmodule

// File: rtl/i2c_busy_track.sv
// Module: i2c_busy_track
// Holds the bus-busy flag. Enabling forces a value picked by the option bit;
// detected starts or accepted own starts set it; detected stops clear it.
// Assumes: own_start is the registered one-cycle start drive request.
module i2c_busy_track
    import i2c_bus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     free_on_en,
    input  bus_evt_t evt,
    input  logic     own_start,
    output logic     busy
);
    logic en_q;

    // Busy flag with enable-time initialisation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            en_q <= 1'b0;
        end else begin
            en_q <= en;
            if (!en)
                busy <= 1'b0;
            else if (!en_q)
                busy <= ~free_on_en;
            else if (evt.stop)
                busy <= 1'b0;
            else if (evt.start || own_start)
                busy <= 1'b1;
        end
    end

    assert_busy_off_when_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    assert_busy_at_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !en_q && !free_on_en) |=> busy);
    assert_free_at_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !en_q && free_on_en) |=> !busy);
    assert_stop_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_q && evt.stop) |=> !busy);
endmodule

// File: rtl/i2c_req_arb.sv
// Module: i2c_req_arb
// Takes software start/stop/release strobes, decides start requests against
// bus ownership, issues one-cycle drive requests, reports the start outcome a
// fixed number of edges after the write, and raises the stop interrupt.
// Assumes: busy comes from i2c_busy_track; strobes last one cycle.
module i2c_req_arb
    import i2c_bus_pkg::*;
#(
    parameter int unsigned STAT_DELAY = STAT_DELAY_DEF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     busy,
    input  bus_evt_t evt,
    input  logic     start_wr,
    input  logic     stop_wr,
    input  logic     release_wr,
    input  logic     stop_ie,
    output logic     start_pend,
    output logic     stop_pend,
    output logic     gen_start,
    output logic     gen_stop,
    output logic     master,
    output logic     active,
    output logic     start_ok,
    output logic     stop_irq
);
    localparam int unsigned CW = $clog2(STAT_DELAY + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(STAT_DELAY);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic          accept;
    logic          decided;
    logic [CW-1:0] stat_cnt;

    // Start is allowed on a free bus or as a repeated start by the owner
    always_comb accept = !busy || master;

    // Request bits, drive pulses and ownership
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
            gen_start  <= 1'b0;
            gen_stop   <= 1'b0;
            master     <= 1'b0;
            decided    <= 1'b0;
        end else begin
            gen_start <= 1'b0;
            gen_stop  <= 1'b0;
            if (stop_pend) begin
                gen_stop  <= 1'b1;
                stop_pend <= 1'b0;
                master    <= 1'b0;
            end else if (start_pend) begin
                gen_start  <= accept;
                decided    <= accept;
                start_pend <= 1'b0;
                if (accept)
                    master <= 1'b1;
            end
            if (start_wr && !start_pend)
                start_pend <= 1'b1;
            if (stop_wr)
                stop_pend <= 1'b1;
            if (release_wr || evt.stop)
                master <= 1'b0;
        end
    end

    // Participation in the transfer seen on the lines
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            active <= 1'b0;
        else if (release_wr || evt.stop)
            active <= 1'b0;
        else if (evt.start)
            active <= 1'b1;
    end

    // Fixed-latency status report of the start outcome
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            stat_cnt <= '0;
            start_ok <= 1'b0;
        end else if (start_wr && !start_pend) begin
            stat_cnt <= CNT_LOAD;
        end else if (stat_cnt != '0) begin
            stat_cnt <= stat_cnt - CNT_ONE;
            if (stat_cnt == CNT_ONE)
                start_ok <= decided;
        end
    end

    // Stop-detected interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_irq <= 1'b0;
        else
            stop_irq <= en && evt.stop && stop_ie;
    end

    assert_drive_from_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gen_start |-> $past(start_pend));
    assert_reject_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_pend && !stop_pend && busy && !master && !release_wr)
        |=> (!gen_start && !start_pend && !master));
    assert_status_on_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && (start_ok != $past(start_ok))) |-> ($past(stat_cnt) == CNT_ONE));
    assert_one_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gen_start, gen_stop}));
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> $past(stop_ie));
    assert_release_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        release_wr |=> (!active && !master));
endmodule

// File: rtl/i2c_bus_ctrl.sv
// Module: i2c_bus_ctrl (top)
// Bus-ownership and start/stop request controller for a multi-master I2C
// port: line monitor, busy tracker and request arbiter.
// Assumes: the bit engine acts on drive_start/drive_stop pulses; raw lines
// may be asynchronous to clk.
module i2c_bus_ctrl
    import i2c_bus_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEF,
    parameter int unsigned STAT_DELAY  = STAT_DELAY_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic enable,
    input  logic free_on_enable,
    input  logic start_wr,
    input  logic stop_wr,
    input  logic release_wr,
    input  logic stop_irq_en,
    output logic bus_busy,
    output logic start_done,
    output logic start_pending,
    output logic stop_pending,
    output logic drive_start,
    output logic drive_stop,
    output logic is_master,
    output logic participating,
    output logic stop_irq
);
    bus_evt_t evt;

    i2c_line_mon #(.STAGES(SYNC_STAGES)) i_line_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .evt     (evt)
    );

    i2c_busy_track i_busy_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (enable),
        .free_on_en (free_on_enable),
        .evt        (evt),
        .own_start  (drive_start),
        .busy       (bus_busy)
    );

    i2c_req_arb #(.STAT_DELAY(STAT_DELAY)) i_req_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (enable),
        .busy       (bus_busy),
        .evt        (evt),
        .start_wr   (start_wr),
        .stop_wr    (stop_wr),
        .release_wr (release_wr),
        .stop_ie    (stop_irq_en),
        .start_pend (start_pending),
        .stop_pend  (stop_pending),
        .gen_start  (drive_start),
        .gen_stop   (drive_stop),
        .master     (is_master),
        .active     (participating),
        .start_ok   (start_done),
        .stop_irq   (stop_irq)
    );
endmodule

// File: tb/test_i2c_bus_ctrl.sv
`timescale 1ns/1ps
module test_i2c_bus_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic enable = 1'b0, free_on_enable = 1'b0;
    logic start_wr = 1'b0, stop_wr = 1'b0, release_wr = 1'b0, stop_irq_en = 1'b0;
    logic bus_busy, start_done, start_pending, stop_pending;
    logic drive_start, drive_stop, is_master, participating, stop_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_bus_ctrl i_i2c_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .enable(enable), .free_on_enable(free_on_enable),
        .start_wr(start_wr), .stop_wr(stop_wr), .release_wr(release_wr),
        .stop_irq_en(stop_irq_en),
        .bus_busy(bus_busy), .start_done(start_done),
        .start_pending(start_pending), .stop_pending(stop_pending),
        .drive_start(drive_start), .drive_stop(drive_stop),
        .is_master(is_master), .participating(participating), .stop_irq(stop_irq)
    );

    // Line pattern table: {scl, sda, expected busy, expected participating}
    localparam int NLINE = 11;
    localparam logic [3:0] LINE_TAB [NLINE] = '{
        4'b1100, 4'b1011, 4'b0011, 4'b0111, 4'b1111, 4'b1011,
        4'b1100, 4'b0100, 4'b0000, 4'b1000, 4'b1100
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Advance n rising edges, then stop at the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // One-cycle strobes; return just after the edge that samples them
    task automatic pulse_start();
        start_wr = 1'b1; tick(1); start_wr = 1'b0;
    endtask
    task automatic pulse_stop();
        stop_wr = 1'b1; tick(1); stop_wr = 1'b0;
    endtask
    task automatic pulse_release();
        release_wr = 1'b1; tick(1); release_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk("R1", "bus_busy", bus_busy, 1'b0);
        chk("R1", "start_done", start_done, 1'b0);
        chk("R1", "pending", start_pending | stop_pending, 1'b0);
        chk("R1", "drives", drive_start | drive_stop, 1'b0);
        chk("R1", "master/part/irq", is_master | participating | stop_irq, 1'b0);

        // R3: enable with free option
        enable = 1'b1; free_on_enable = 1'b1; stop_irq_en = 1'b1;
        tick(1);
        chk("R3", "bus_busy", bus_busy, 1'b0);

        // R4: line pattern table
        for (int i = 0; i < NLINE; i++) begin
            scl = LINE_TAB[i][3];
            sda = LINE_TAB[i][2];
            tick(3);
            chk("R4", $sformatf("busy step %0d", i), bus_busy, LINE_TAB[i][1]);
            chk("R4", $sformatf("part step %0d", i), participating, LINE_TAB[i][0]);
        end

        // R5/R7: accepted start on a free bus
        pulse_start();
        chk("R5", "start_pending set", start_pending, 1'b1);
        tick(1);
        chk("R5", "drive_start", drive_start, 1'b1);
        chk("R5", "is_master", is_master, 1'b1);
        chk("R5", "start_pending cleared", start_pending, 1'b0);
        tick(1);
        chk("R5", "drive_start one cycle", drive_start, 1'b0);
        chk("R5", "bus_busy", bus_busy, 1'b1);
        tick(2);
        chk("R7", "start_done before 5th edge", start_done, 1'b0);
        tick(1);
        chk("R7", "start_done at 5th edge", start_done, 1'b1);

        // R12: repeated start while master
        pulse_start();
        tick(1);
        chk("R12", "drive_start repeated", drive_start, 1'b1);
        tick(5);

        // R10: release drops participation, keeps busy
        sda = 1'b0;
        tick(3);
        chk("R4", "participating after start", participating, 1'b1);
        pulse_release();
        chk("R10", "participating", participating, 1'b0);
        chk("R10", "is_master", is_master, 1'b0);
        chk("R10", "bus_busy kept", bus_busy, 1'b1);
        tick(3);
        chk("R10", "participating stays 0", participating, 1'b0);

        // R6/R7: rejected start
        pulse_start();
        tick(1);
        chk("R6", "drive_start", drive_start, 1'b0);
        chk("R6", "start_pending cleared", start_pending, 1'b0);
        chk("R6", "is_master", is_master, 1'b0);
        tick(3);
        chk("R7", "start_done before 5th edge", start_done, 1'b1);
        tick(1);
        chk("R7", "start_done rejected", start_done, 1'b0);

        // R8/R9: stop request, stop seen with interrupt disabled
        stop_irq_en = 1'b0;
        pulse_stop();
        chk("R8", "stop_pending set", stop_pending, 1'b1);
        tick(1);
        chk("R8", "drive_stop", drive_stop, 1'b1);
        chk("R8", "stop_pending cleared", stop_pending, 1'b0);
        chk("R8", "bus_busy held", bus_busy, 1'b1);
        sda = 1'b1;
        tick(2);
        chk("R8", "busy before detect", bus_busy, 1'b1);
        chk("R9", "no irq", stop_irq, 1'b0);
        tick(1);
        chk("R8", "busy cleared", bus_busy, 1'b0);
        chk("R9", "no irq when disabled", stop_irq, 1'b0);

        // R9: interrupt pulse when enabled
        stop_irq_en = 1'b1;
        sda = 1'b0;
        tick(3);
        sda = 1'b1;
        tick(2);
        chk("R9", "irq not early", stop_irq, 1'b0);
        tick(1);
        chk("R9", "irq pulse", stop_irq, 1'b1);
        chk("R9", "busy with irq", bus_busy, 1'b0);
        tick(1);
        chk("R9", "irq one cycle", stop_irq, 1'b0);

        // R11: disable clears state; writes ignored
        pulse_start();
        tick(5);
        chk("R11", "pre start_done", start_done, 1'b1);
        enable = 1'b0;
        tick(1);
        chk("R11", "bus_busy", bus_busy, 1'b0);
        chk("R11", "is_master", is_master, 1'b0);
        chk("R11", "start_done", start_done, 1'b0);
        pulse_start();
        chk("R11", "start ignored", start_pending, 1'b0);
        pulse_stop();
        chk("R11", "stop ignored", stop_pending, 1'b0);
        tick(1);
        chk("R11", "no drive", drive_start | drive_stop, 1'b0);

        // R2: enable assuming busy; freed only by a stop
        free_on_enable = 1'b0;
        enable = 1'b1;
        tick(1);
        chk("R2", "busy at enable", bus_busy, 1'b1);
        tick(5);
        chk("R2", "busy on idle lines", bus_busy, 1'b1);
        pulse_stop();
        tick(1);
        chk("R8", "drive_stop from busy", drive_stop, 1'b1);
        scl = 1'b0; tick(2);
        sda = 1'b0; tick(2);
        scl = 1'b1; tick(2);
        chk("R2", "busy before stop", bus_busy, 1'b1);
        sda = 1'b1;
        tick(3);
        chk("R2", "freed by stop", bus_busy, 1'b0);
        pulse_start();
        tick(1);
        chk("R5", "start after freed", drive_start, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule